// File: doc/BRIEF.md
# Dual-Rate CAN Bit Sampler

This block turns an oversampled CAN receive line into one sampled bit per bit time. It keeps a cycle counter that restarts on every recessive-to-dominant change of the line. When the counter reaches the configured sample-point offset, it emits a one-cycle strobe together with the line level. The offset is the active bit period multiplied by a percentage, rounded down.

Two bit periods, both given in clock cycles, are held: a nominal period and a faster data-phase period. A frame parser further downstream drives three controls. `go_fast` selects the fast period and forces the timing to re-anchor in that same cycle. `go_nominal` returns to the nominal period. `frame_end` stops sampling until the next dominant edge arrives. The receive input passes through a two-flop synchronizer. Configuration is captured only while the bus is idle.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset, `smp_strobe` and `fast_active` are 0, and no strobe appears while `rx_in` stays recessive (1).
- R2: From idle, a 1-to-0 change of `rx_in` anchors the timing. The first strobe is seen after the (4 + floor(P*pct/100))-th rising clock edge, counting the first edge that samples the new level as edge 1. P is the nominal period.
- R3: After the first strobe, strobes repeat every P cycles, each one cycle wide. `smp_bit` carries the synchronized line level at the sample point. A 0-to-1 change of the line does not re-anchor.
- R4: A 1-to-0 change during a frame re-anchors the timing. The next strobe follows after 4 + floor(P*pct/100) edges.
- R5: A `go_fast` pulse during a frame sets `fast_active` and restarts the count in that cycle. The next strobe comes 2 + floor(F*pct/100) edges after the edge that samples the pulse, where F is the fast period. Later strobes are F cycles apart.
- R6: A `go_nominal` pulse clears `fast_active` on the next edge. From the second strobe after the pulse, the spacing is P again.
- R7: A `frame_end` pulse stops all strobes and clears `fast_active`. Sampling resumes only on a new 1-to-0 change.
- R8: The period and percentage inputs are captured only while idle. Changing them during a frame leaves the strobe spacing unchanged.
- R9: `go_fast` while idle has no effect: `fast_active` stays 0, no strobe appears, and the next frame runs at P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous CAN receive line, 1 = recessive |
| cfg_nom_period | input | PER_W | Nominal bit period in clock cycles |
| cfg_fast_period | input | PER_W | Data-phase bit period in clock cycles |
| cfg_sample_pct | input | PCT_W | Sample point in percent of the bit period |
| go_fast | input | 1 | Pulse: adopt the fast period and re-anchor |
| go_nominal | input | 1 | Pulse: return to the nominal period |
| frame_end | input | 1 | Pulse: stop sampling and return to idle |
| smp_strobe | output | 1 | One-cycle strobe at each sample point |
| smp_bit | output | 1 | Line level captured at the strobe |
| fast_active | output | 1 | 1 while the fast period is in use |

## Verification
Each timing result has its own latency, counted in clock edges. After a line fall from idle, or during a frame, the first strobe comes 4 + offset edges later: two synchronizer stages, one anchor cycle and one output register. After a `go_fast` pulse it comes 2 + fast offset edges later. After that, strobes are one period apart. `fast_active` changes one edge after its control pulse. The bench drives every input at a falling clock edge and counts rising edges until it sees the strobe at a falling edge. It issues each control pulse just after a strobe, so a strobe already due cannot fall inside the measured window.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;

  // Sample-point offset in cycles: period scaled by a percentage, floored.
  function automatic int sp_offset(input int period, input int pct);
    return (period * pct) / 100;
  endfunction

endpackage

// File: rtl/can_bs_sync.sv
module can_bs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic rx_s,
  output logic fall
);
  // [0] first stage, [1] synchronized level, [2] previous synchronized level
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[1:0], rx_async};
  end

  assign rx_s = sh_q[1];
  assign fall = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/can_bs_rate.sv
module can_bs_rate #(
  parameter int PER_W    = 12,
  parameter int PCT_W    = 7,
  parameter int DEF_NOM  = 250,
  parameter int DEF_FAST = 125,
  parameter int DEF_PCT  = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             go_fast,
  input  logic             go_nominal,
  input  logic             frame_end,
  input  logic [PER_W-1:0] cfg_nom,
  input  logic [PER_W-1:0] cfg_fast,
  input  logic [PCT_W-1:0] cfg_pct,
  output logic             fast_q,
  output logic [PER_W-1:0] cur_period,
  output logic [PER_W-1:0] cur_sp
);
  import can_bs_pkg::*;

  localparam logic [PER_W-1:0] RST_NOM     = PER_W'(DEF_NOM);
  localparam logic [PER_W-1:0] RST_FAST    = PER_W'(DEF_FAST);
  localparam logic [PER_W-1:0] RST_SP_NOM  = PER_W'((DEF_NOM * DEF_PCT) / 100);
  localparam logic [PER_W-1:0] RST_SP_FAST = PER_W'((DEF_FAST * DEF_PCT) / 100);

  logic [PER_W-1:0] nom_q, fper_q, sp_nom_q, sp_fast_q;

  // Configuration is captured only while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nom_q     <= RST_NOM;
      fper_q    <= RST_FAST;
      sp_nom_q  <= RST_SP_NOM;
      sp_fast_q <= RST_SP_FAST;
    end else if (!active) begin
      nom_q     <= cfg_nom;
      fper_q    <= cfg_fast;
      sp_nom_q  <= PER_W'(sp_offset(int'(cfg_nom), int'(cfg_pct)));
      sp_fast_q <= PER_W'(sp_offset(int'(cfg_fast), int'(cfg_pct)));
    end
  end

  // Rate selection: end of frame has priority over the parser requests.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 fast_q <= 1'b0;
    else if (frame_end)         fast_q <= 1'b0;
    else if (go_fast && active) fast_q <= 1'b1;
    else if (go_nominal)        fast_q <= 1'b0;
  end

  assign cur_period = fast_q ? fper_q    : nom_q;
  assign cur_sp     = fast_q ? sp_fast_q : sp_nom_q;

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ($stable(nom_q) && $stable(fper_q) && $stable(sp_nom_q)));
  a_r5_fast_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (go_fast && active && !frame_end) |=> fast_q);
  a_r6_revert: assert property (@(posedge clk) disable iff (!rst_n)
    (go_nominal && !go_fast) |=> !fast_q);
  a_r9_idle_no_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !fast_q) |=> !fast_q);
endmodule

// File: rtl/can_bs_timer.sv
module can_bs_timer #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             rx_s,
  input  logic             go_fast,
  input  logic             frame_end,
  input  logic [PER_W-1:0] cur_period,
  input  logic [PER_W-1:0] cur_sp,
  output logic             active,
  output logic             strobe,
  output logic             bit_q
);
  logic [PER_W-1:0] cnt_q;
  logic             at_sp, at_wrap, force_anchor;

  assign at_sp        = active && (cnt_q == cur_sp);
  assign at_wrap      = cnt_q >= (cur_period - PER_W'(1));
  assign force_anchor = go_fast && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (frame_end) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (force_anchor) begin
      cnt_q  <= '0;
    end else if (fall) begin
      active <= 1'b1;
      cnt_q  <= '0;
    end else if (active) begin
      cnt_q  <= at_wrap ? '0 : cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      bit_q  <= 1'b1;
    end else begin
      strobe <= at_sp && !frame_end;
      if (at_sp) bit_q <= rx_s;
    end
  end

  a_r4_reanchor: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !frame_end) |=> (active && cnt_q == '0));
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!active && !strobe));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !strobe);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
  parameter int PER_W    = 12,
  parameter int PCT_W    = 7,
  parameter int DEF_NOM  = 250,
  parameter int DEF_FAST = 125,
  parameter int DEF_PCT  = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic [PER_W-1:0] cfg_nom_period,
  input  logic [PER_W-1:0] cfg_fast_period,
  input  logic [PCT_W-1:0] cfg_sample_pct,
  input  logic             go_fast,
  input  logic             go_nominal,
  input  logic             frame_end,
  output logic             smp_strobe,
  output logic             smp_bit,
  output logic             fast_active
);
  logic             rx_s, fall, active;
  logic [PER_W-1:0] cur_period, cur_sp;

  can_bs_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_async (rx_in),
    .rx_s     (rx_s),
    .fall     (fall)
  );

  can_bs_rate #(
    .PER_W(PER_W), .PCT_W(PCT_W),
    .DEF_NOM(DEF_NOM), .DEF_FAST(DEF_FAST), .DEF_PCT(DEF_PCT)
  ) u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .go_fast    (go_fast),
    .go_nominal (go_nominal),
    .frame_end  (frame_end),
    .cfg_nom    (cfg_nom_period),
    .cfg_fast   (cfg_fast_period),
    .cfg_pct    (cfg_sample_pct),
    .fast_q     (fast_active),
    .cur_period (cur_period),
    .cur_sp     (cur_sp)
  );

  can_bs_timer #(.PER_W(PER_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall       (fall),
    .rx_s       (rx_s),
    .go_fast    (go_fast),
    .frame_end  (frame_end),
    .cur_period (cur_period),
    .cur_sp     (cur_sp),
    .active     (active),
    .strobe     (smp_strobe),
    .bit_q      (smp_bit)
  );
endmodule

// File: tb/tb_can_bit_sampler.sv
`timescale 1ns/1ps
module tb_can_bit_sampler;
  localparam int PER_W = 12;
  localparam int PCT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic [PER_W-1:0] cfg_nom_period  = PER_W'(25);
  logic [PER_W-1:0] cfg_fast_period = PER_W'(10);
  logic [PCT_W-1:0] cfg_sample_pct  = PCT_W'(70);
  logic go_fast = 1'b0, go_nominal = 1'b0, frame_end = 1'b0;
  logic smp_strobe, smp_bit, fast_active;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  can_bit_sampler #(.PER_W(PER_W), .PCT_W(PCT_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
    .cfg_nom_period(cfg_nom_period), .cfg_fast_period(cfg_fast_period),
    .cfg_sample_pct(cfg_sample_pct), .go_fast(go_fast),
    .go_nominal(go_nominal), .frame_end(frame_end),
    .smp_strobe(smp_strobe), .smp_bit(smp_bit), .fast_active(fast_active)
  );

  // {nominal period, percent, expected offset floor(P*pct/100)}
  localparam int VEC [5][3] = '{
    '{25, 70, 17}, '{10, 50, 5}, '{8, 75, 6}, '{40, 80, 32}, '{13, 33, 4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts at a negedge. which: 0 = line falls, 1 = go_fast, 2 = go_nominal,
  // 3 = nothing. Returns rising edges until the strobe is seen.
  task automatic fire_wait(input int which, output int n);
    if (which == 0) rx_in = 1'b0;
    if (which == 1) go_fast = 1'b1;
    if (which == 2) go_nominal = 1'b1;
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      go_fast = 1'b0;
      go_nominal = 1'b0;
      if (smp_strobe || n > 5000) break;
    end
  endtask

  task automatic go_idle(input int nom, input int pct);
    cfg_nom_period = PER_W'(nom);
    cfg_sample_pct = PCT_W'(pct);
    rx_in = 1'b1;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic count_strobes(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (smp_strobe) cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and quiet idle
    chk(smp_strobe == 1'b0, "R1 strobe after reset", int'(smp_strobe), 0);
    chk(fast_active == 1'b0, "R1 fast after reset", int'(fast_active), 0);
    count_strobes(100, c);
    chk(c == 0, "R1 idle strobes", c, 0);

    // R2/R3: vector table
    for (int v = 0; v < 5; v++) begin
      go_idle(VEC[v][0], VEC[v][1]);
      fire_wait(0, n);
      chk(n == VEC[v][2] + 4, "R2 first strobe latency", n, VEC[v][2] + 4);
      chk(smp_bit == 1'b0, "R3 first bit value", int'(smp_bit), 0);
      rx_in = 1'b1;
      fire_wait(3, n);
      chk(n == VEC[v][0], "R3 strobe spacing", n, VEC[v][0]);
      chk(smp_bit == 1'b1, "R3 second bit value", int'(smp_bit), 1);
      fire_wait(3, n);
      chk(n == VEC[v][0], "R3 spacing after rise", n, VEC[v][0]);
    end

    // R3: strobe is one cycle wide
    @(negedge clk);
    chk(smp_strobe == 1'b0, "R3 pulse width", int'(smp_strobe), 0);

    go_idle(25, 70);
    fire_wait(0, n);
    chk(n == 21, "R2 frame start", n, 21);
    rx_in = 1'b1;
    fire_wait(3, n);
    // R4: re-anchor on a fall during the frame
    fire_wait(0, n);
    chk(n == 21, "R4 re-anchor latency", n, 21);

    // R8: config change during a frame is ignored
    cfg_nom_period = PER_W'(40);
    fire_wait(3, n);
    chk(n == 25, "R8 spacing unchanged", n, 25);

    // R5: fast switch with forced re-anchor (fast 10, offset 7)
    fire_wait(1, n);
    chk(n == 9, "R5 fast first strobe", n, 9);
    chk(fast_active == 1'b1, "R5 fast flag", int'(fast_active), 1);
    fire_wait(3, n);
    chk(n == 10, "R5 fast spacing", n, 10);

    // R6: revert to nominal
    cfg_nom_period = PER_W'(25);
    fire_wait(2, n);
    chk(fast_active == 1'b0, "R6 fast flag cleared", int'(fast_active), 0);
    fire_wait(3, n);
    chk(n == 25, "R6 nominal spacing", n, 25);

    // R7: end of frame
    rx_in = 1'b1;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk(fast_active == 1'b0, "R7 fast after end", int'(fast_active), 0);
    count_strobes(100, c);
    chk(c == 0, "R7 no strobes after end", c, 0);

    // R9: go_fast while idle is ignored
    go_fast = 1'b1;
    @(negedge clk);
    go_fast = 1'b0;
    count_strobes(50, c);
    chk(c == 0, "R9 no strobes", c, 0);
    chk(fast_active == 1'b0, "R9 fast flag idle", int'(fast_active), 0);
    fire_wait(0, n);
    chk(n == 21, "R9 next frame latency", n, 21);
    fire_wait(3, n);
    chk(n == 25, "R9 next frame nominal", n, 25);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule